// File: doc/BRIEF.md
# PCI Host Bridge CPU-Side Register Interface

This block is the register front end that a processor sees when it talks to a simple PCI host bridge. It is a 32-bit local bus slave. One window of the register space holds the bridge's own 256-byte configuration header. Three control registers hold:

- a configuration address,
- a memory base,
- an I/O base.

A single data port turns each local bus access into one downstream configuration transaction. That transaction is addressed by the stored configuration address.

Software programs the configuration address register first. It then reads or writes the data port. While the downstream request/response interface finishes the transaction, the block stalls the local bus by holding ready low. The block also shows the current I/O window base, taken from the I/O base register, on an output. It routes interrupt level changes from bus devices onto four lines, using each device's slot number to pick the line.

Top module: `pcihb_regif`

## Requirements
- R1: After reset, the registers at 0x1C0, 0x1C4 and 0x1C8 read zero. `io_win_base`, `irq_out` and `cfg_req` are zero.
- R2: After reset, the header word at 0x004 reads 0x0290_0080. The low half is the command field with the wait-cycle bit (bit 7) set. The high half is the status field with capability-list (bit 4), fast back-to-back (bit 7) and medium select timing (bit 9) set.
- R3: Word-aligned offsets 0x000 to 0x0FC are each a plain 32-bit storage word of the header. A value written there reads back unchanged.
- R4: Offset 0x1C0, the configuration address, stores all 32 written bits and reads them back.
- R5: Offset 0x1C4, the memory base, stores only the bits under mask 0xFF00_0001. All other bits read zero.
- R6: Offset 0x1C8, the I/O base, stores only the bits under mask 0xFFFC_0001. After the write, `io_win_base` equals bits 31:18 of the written value with bits 17:0 zero. The window is 0x40000 bytes long.
- R7: A write to 0x220 raises `cfg_req` exactly once, with `cfg_we`=1, `cfg_addr` equal to the stored configuration address and `cfg_wdata` equal to the written data. `cfg_req` stays high and stable until `cfg_ack`. `lb_ready` stays low until the cycle after `cfg_ack`.
- R8: A read of 0x220 raises `cfg_req` exactly once, with `cfg_we`=0. It completes in the cycle after `cfg_ack` and returns the `cfg_rdata` value sampled with that acknowledge.
- R9: Undecoded offsets read zero, and writes to them change no register. Undecoded offsets are 0x100 to 0x1BC, 0x1CC to 0x21C, 0x224 and above, and any offset with bits 1:0 nonzero.
- R10: An access with `lb_size` other than 2'b10 (32 bits) completes in the same cycle. It reads zero, changes no register and issues no downstream request.
- R11: On `irq_evt`, line (`irq_slot` mod 4) of `irq_out` takes `irq_level` from the next cycle on. The other lines keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lb_sel | input | 1 | Local bus access request, held until `lb_ready` |
| lb_wr | input | 1 | 1 = write, 0 = read |
| lb_size | input | 2 | Access size; 2'b10 = 32-bit |
| lb_addr | input | 12 | Byte offset |
| lb_wdata | input | 32 | Write data |
| lb_rdata | output | 32 | Read data, valid while `lb_ready` |
| lb_ready | output | 1 | Access completes at the next clock edge |
| cfg_req | output | 1 | Downstream configuration request |
| cfg_we | output | 1 | Downstream request is a write |
| cfg_addr | output | 32 | Downstream configuration address |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_ack | input | 1 | Downstream completion strobe |
| cfg_rdata | input | 32 | Downstream read data, valid with `cfg_ack` |
| io_win_base | output | 32 | Current I/O window base address |
| irq_evt | input | 1 | Interrupt level change strobe |
| irq_slot | input | 5 | Slot number of the device that signals the change |
| irq_level | input | 1 | New interrupt level |
| irq_out | output | 4 | Routed interrupt lines |

## Verification
The checker assumes the following about the inputs:

- The local bus master keeps `lb_sel` and the address, size and data steady from the start of an access until `lb_ready` is seen.
- The downstream side raises `cfg_ack` only while `cfg_req` is high, and for a single cycle.

The read-return property and the stall properties rely on these two rules. The bench drives all inputs half a cycle away from the active edge. Its responder pulses the acknowledge once per request after a programmable delay, and the driver releases `lb_sel` only after the completing edge.

// File: rtl/pcihb_regif.sv
`timescale 1ns/1ps
module pcihb_regif #(
  parameter int          AW           = 12,
  parameter int          HDR_WORDS    = 64,
  parameter int          NUM_IRQ      = 4,
  parameter int          SLOT_W       = 5,
  parameter int          IO_WIN_BYTES = 32'h0004_0000,
  parameter logic [31:0] HDR_ID_RST   = 32'h0000_0000,
  parameter logic [31:0] HDR_CS_RST   = 32'h0290_0080,
  parameter logic [31:0] MEM_MASK     = 32'hFF00_0001,
  parameter logic [31:0] IO_MASK      = 32'hFFFC_0001,
  parameter logic [11:0] OFS_CADDR    = 12'h1C0,
  parameter logic [11:0] OFS_MBASE    = 12'h1C4,
  parameter logic [11:0] OFS_IOBASE   = 12'h1C8,
  parameter logic [11:0] OFS_DATA     = 12'h220
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lb_sel,
  input  logic              lb_wr,
  input  logic [1:0]        lb_size,
  input  logic [AW-1:0]     lb_addr,
  input  logic [31:0]       lb_wdata,
  output logic [31:0]       lb_rdata,
  output logic              lb_ready,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [31:0]       cfg_addr,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_ack,
  input  logic [31:0]       cfg_rdata,
  output logic [31:0]       io_win_base,
  input  logic              irq_evt,
  input  logic [SLOT_W-1:0] irq_slot,
  input  logic              irq_level,
  output logic [NUM_IRQ-1:0] irq_out
);
  localparam int          HIX_W   = $clog2(HDR_WORDS);
  localparam logic [AW:0] HDR_LIM = (AW+1)'(HDR_WORDS * 4);
  localparam int          IO_SH   = $clog2(IO_WIN_BYTES);
  localparam logic [31:0] WIN_MSK = ~((32'h1 << IO_SH) - 32'h1);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DONE} dp_st_t;

  logic [31:0] hdr_q [HDR_WORDS];
  logic [31:0] caddr_q, mbase_q, iobase_q, dp_rd_q;
  logic [SLOT_W-1:0] irq_line;
  dp_st_t st_q;

  wire word_acc = (lb_size == 2'b10) && (lb_addr[1:0] == 2'b00);
  wire hit_hdr  = word_acc && ({1'b0, lb_addr} < HDR_LIM);
  wire hit_ca   = word_acc && (lb_addr == OFS_CADDR[AW-1:0]);
  wire hit_mb   = word_acc && (lb_addr == OFS_MBASE[AW-1:0]);
  wire hit_io   = word_acc && (lb_addr == OFS_IOBASE[AW-1:0]);
  wire hit_dp   = word_acc && (lb_addr == OFS_DATA[AW-1:0]);
  wire [HIX_W-1:0] hix = lb_addr[HIX_W+1:2];

  assign lb_ready    = lb_sel && (!hit_dp || st_q == ST_DONE);
  wire   wr_fire     = lb_ready && lb_wr;
  assign cfg_req     = (st_q == ST_REQ);
  assign cfg_addr    = caddr_q;
  assign io_win_base = iobase_q & WIN_MSK;
  assign irq_line    = irq_slot % SLOT_W'(NUM_IRQ);

  always_comb begin
    lb_rdata = '0;
    if (hit_hdr)     lb_rdata = hdr_q[hix];
    else if (hit_ca) lb_rdata = caddr_q;
    else if (hit_mb) lb_rdata = mbase_q;
    else if (hit_io) lb_rdata = iobase_q;
    else if (hit_dp) lb_rdata = dp_rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HDR_WORDS; i++)
        hdr_q[i] <= (i == 0) ? HDR_ID_RST : (i == 1) ? HDR_CS_RST : 32'h0;
    end else if (wr_fire && hit_hdr) begin
      hdr_q[hix] <= lb_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caddr_q  <= '0;
      mbase_q  <= '0;
      iobase_q <= '0;
    end else if (wr_fire) begin
      if (hit_ca) caddr_q  <= lb_wdata;
      if (hit_mb) mbase_q  <= lb_wdata & MEM_MASK;
      if (hit_io) iobase_q <= lb_wdata & IO_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cfg_we    <= 1'b0;
      cfg_wdata <= '0;
      dp_rd_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (lb_sel && hit_dp) begin
          st_q      <= ST_REQ;
          cfg_we    <= lb_wr;
          cfg_wdata <= lb_wdata;
        end
        ST_REQ: if (cfg_ack) begin
          st_q    <= ST_DONE;
          dp_rd_q <= cfg_rdata;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 irq_out[g] <= 1'b0;
      else if (irq_evt && irq_line == SLOT_W'(g)) irq_out[g] <= irq_level;
    end
  end
endmodule

module pcihb_regif_chk #(
  parameter int          AW           = 12,
  parameter int          NUM_IRQ      = 4,
  parameter int          SLOT_W       = 5,
  parameter int          IO_WIN_BYTES = 32'h0004_0000,
  parameter logic [31:0] MEM_MASK     = 32'hFF00_0001,
  parameter logic [11:0] OFS_MBASE    = 12'h1C4,
  parameter logic [11:0] OFS_IOBASE   = 12'h1C8,
  parameter logic [11:0] OFS_DATA     = 12'h220
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lb_sel,
  input logic              lb_wr,
  input logic [1:0]        lb_size,
  input logic [AW-1:0]     lb_addr,
  input logic [31:0]       lb_wdata,
  input logic [31:0]       lb_rdata,
  input logic              lb_ready,
  input logic              cfg_req,
  input logic              cfg_we,
  input logic [31:0]       cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic              cfg_ack,
  input logic [31:0]       cfg_rdata,
  input logic [31:0]       io_win_base,
  input logic              irq_evt,
  input logic [SLOT_W-1:0] irq_slot,
  input logic              irq_level,
  input logic [NUM_IRQ-1:0] irq_out
);
  localparam int          IO_SH   = $clog2(IO_WIN_BYTES);
  localparam logic [31:0] WIN_MSK = ~((32'h1 << IO_SH) - 32'h1);
  wire word = (lb_size == 2'b10);

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req);
  a_r7_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> $stable(cfg_we) && $stable(cfg_addr) && $stable(cfg_wdata));
  a_r7_bus_stall: assert property (@(posedge clk) disable iff (!rst_n)
    lb_sel && word && lb_addr == OFS_DATA[AW-1:0] && cfg_req |-> !lb_ready);
  a_r8_read_return: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_ack && !cfg_we |=> lb_ready && lb_rdata == $past(cfg_rdata));
  a_r5_mbase_mask: assert property (@(posedge clk) disable iff (!rst_n)
    lb_ready && !lb_wr && word && lb_addr == OFS_MBASE[AW-1:0] |-> (lb_rdata & ~MEM_MASK) == 32'h0);
  a_r6_io_window: assert property (@(posedge clk) disable iff (!rst_n)
    lb_ready && lb_wr && word && lb_addr == OFS_IOBASE[AW-1:0] |=> io_win_base == ($past(lb_wdata) & WIN_MSK));
  a_r10_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    lb_sel && !word |-> lb_ready && (lb_wr || lb_rdata == 32'h0));
  a_r10_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> $past(lb_sel) && $past(word) && $past(lb_addr) == OFS_DATA[AW-1:0]);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq_chk
    a_r11_irq_route: assert property (@(posedge clk) disable iff (!rst_n)
      irq_evt && (irq_slot % SLOT_W'(NUM_IRQ)) == SLOT_W'(g) |=> irq_out[g] == $past(irq_level));
  end
endmodule

bind pcihb_regif pcihb_regif_chk #(
  .AW(AW), .NUM_IRQ(NUM_IRQ), .SLOT_W(SLOT_W), .IO_WIN_BYTES(IO_WIN_BYTES),
  .MEM_MASK(MEM_MASK), .OFS_MBASE(OFS_MBASE), .OFS_IOBASE(OFS_IOBASE), .OFS_DATA(OFS_DATA)
) u_chk (.*);

// File: tb/pcihb_regif_tb.sv
`timescale 1ns/1ps
module pcihb_regif_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lb_sel = 0, lb_wr = 0, cfg_ack = 0, irq_evt = 0, irq_level = 0;
  logic [1:0] lb_size = 2'b10;
  logic [11:0] lb_addr = '0;
  logic [31:0] lb_wdata = '0, cfg_rdata = '0;
  logic [4:0] irq_slot = '0;
  logic [31:0] lb_rdata, cfg_addr, cfg_wdata, io_win_base;
  logic lb_ready, cfg_req, cfg_we;
  logic [3:0] irq_out;

  pcihb_regif u_dut (.*);

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  int resp_delay = 2, n_req = 0, wcnt = 0;
  logic [31:0] resp_val = '0, seen_addr, seen_wdata;
  logic seen_we, prev_req = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk); #2;
    if (lb_sel && lb_ready && !lb_wr) begin
      if (exp_q.size() == 0) chk("unexpected read", lb_rdata, 32'hxxxx_xxxx);
      else chk(tag_q.pop_front(), lb_rdata, exp_q.pop_front());
    end
  end

  // downstream responder
  initial forever begin
    @(negedge clk);
    cfg_ack = 1'b0;
    if (cfg_req && !prev_req) begin
      n_req++; seen_addr = cfg_addr; seen_we = cfg_we; seen_wdata = cfg_wdata;
    end
    prev_req = cfg_req;
    if (cfg_req) begin
      wcnt++;
      if (wcnt >= resp_delay) begin cfg_ack = 1'b1; cfg_rdata = resp_val; end
    end else wcnt = 0;
  end

  task automatic drive(logic wr, logic [1:0] sz, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    lb_sel = 1; lb_wr = wr; lb_size = sz; lb_addr = a; lb_wdata = d;
    #1;
    while (!lb_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    lb_sel = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    drive(1'b1, 2'b10, a, d);
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag, logic [1:0] sz = 2'b10);
    exp_q.push_back(exp); tag_q.push_back(tag);
    drive(1'b0, sz, a, 32'h0);
  endtask

  task automatic irq(logic [4:0] s, logic lvl, logic [3:0] exp);
    @(negedge clk); irq_evt = 1; irq_slot = s; irq_level = lvl;
    @(negedge clk); irq_evt = 0; #1;
    chk("R11 irq routing", {28'h0, irq_out}, {28'h0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 io_win_base reset", io_win_base, 32'h0);
    chk("R1 irq_out reset", {28'h0, irq_out}, 32'h0);
    chk("R1 cfg_req reset", {31'h0, cfg_req}, 32'h0);
    rd(12'h1C0, 32'h0, "R1 cfg addr reset");
    rd(12'h1C4, 32'h0, "R1 mem base reset");
    rd(12'h1C8, 32'h0, "R1 io base reset");
    rd(12'h004, 32'h0290_0080, "R2 command/status default");

    wr(12'h000, 32'hA5A5_1234); wr(12'h0FC, 32'hDEAD_BEEF); wr(12'h040, 32'h1122_3344);
    wr(12'h004, 32'h0000_0147);
    rd(12'h000, 32'hA5A5_1234, "R3 header word 0x000");
    rd(12'h0FC, 32'hDEAD_BEEF, "R3 header word 0x0FC");
    rd(12'h040, 32'h1122_3344, "R3 header word 0x040");
    rd(12'h004, 32'h0000_0147, "R3 header word 0x004");

    wr(12'h1C0, 32'h8000_0810);
    rd(12'h1C0, 32'h8000_0810, "R4 cfg addr readback");

    wr(12'h1C4, 32'hFFFF_FFFF);
    rd(12'h1C4, 32'hFF00_0001, "R5 mem base all ones");
    wr(12'h1C4, 32'h1234_5678);
    rd(12'h1C4, 32'h1200_0000, "R5 mem base pattern");

    wr(12'h1C8, 32'hFFFF_FFFF);
    rd(12'h1C8, 32'hFFFC_0001, "R6 io base all ones");
    @(negedge clk); #1;
    chk("R6 io window all ones", io_win_base, 32'hFFFC_0000);
    wr(12'h1C8, 32'h0007_ABCD);
    rd(12'h1C8, 32'h0004_0001, "R6 io base pattern");
    @(negedge clk); #1;
    chk("R6 io window pattern", io_win_base, 32'h0004_0000);

    wr(12'h1C0, 32'h8000_0800);
    resp_delay = 3; n0 = n_req;
    wr(12'h220, 32'hCAFE_F00D);
    chk("R7 one request per write", n_req, n0 + 1);
    chk("R7 write flag", {31'h0, seen_we}, 32'h1);
    chk("R7 write address", seen_addr, 32'h8000_0800);
    chk("R7 write data", seen_wdata, 32'hCAFE_F00D);

    resp_val = 32'h1234_ABCD; n0 = n_req;
    rd(12'h220, 32'h1234_ABCD, "R8 read data slow");
    chk("R8 one request per read", n_req, n0 + 1);
    chk("R8 read flag", {31'h0, seen_we}, 32'h0);
    wr(12'h1C0, 32'h8000_1004);
    resp_delay = 1; resp_val = 32'h5A5A_0F0F; n0 = n_req;
    rd(12'h220, 32'h5A5A_0F0F, "R8 read data fast");
    chk("R8 read address", seen_addr, 32'h8000_1004);
    chk("R8 single request fast", n_req, n0 + 1);

    rd(12'h100, 32'h0, "R9 undecoded 0x100");
    rd(12'h1BC, 32'h0, "R9 undecoded 0x1BC");
    rd(12'h1CC, 32'h0, "R9 undecoded 0x1CC");
    rd(12'h224, 32'h0, "R9 undecoded 0x224");
    rd(12'h1C2, 32'h0, "R9 unaligned read");
    wr(12'h1CC, 32'hFFFF_FFFF); wr(12'h1C1, 32'hFFFF_FFFF); wr(12'h0FD, 32'h0);
    rd(12'h1C0, 32'h8000_1004, "R9 cfg addr untouched");
    rd(12'h1C4, 32'h1200_0000, "R9 mem base untouched");
    rd(12'h0FC, 32'hDEAD_BEEF, "R9 header untouched");

    n0 = n_req;
    rd(12'h1C0, 32'h0, "R10 narrow read zero", 2'b01);
    drive(1'b1, 2'b01, 12'h1C0, 32'h0BAD_0BAD);
    rd(12'h1C0, 32'h8000_1004, "R10 narrow write ignored");
    rd(12'h220, 32'h0, "R10 narrow data port read", 2'b00);
    drive(1'b1, 2'b00, 12'h220, 32'h1);
    repeat (3) @(negedge clk);
    chk("R10 no downstream request", n_req, n0);

    irq(5'd5, 1'b1, 4'b0010);
    irq(5'd2, 1'b1, 4'b0110);
    irq(5'd1, 1'b0, 4'b0100);
    irq(5'd7, 1'b1, 4'b1100);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule